// File: doc/BRIEF.md
# I2C Master Stop-Condition Controller

This block lives inside an I2C master. Software asks for a stop by writing a command bit. The block decides whether that write is legal in the present bus phase. It keeps the request pending while it produces the stop condition on SCL and SDA, and then clears the request by itself.

The block only pulls the bus lines low, through two open-drain enables. Either line goes high only because the block stops pulling it and the pull-up raises it. Start generation, byte shifting, acknowledge handling and address matching live elsewhere in the master. Here they appear only as status inputs: the wait flags after the eighth and ninth clock, the direction, the start-request bit, arbitration loss and communication exit.

The block carries no data stream, so there is no valid/ready interface. The write strobe is a plain single-cycle command, and every status pin is level-sensitive.

Top module: `i2c_stop_ctrl`

## Requirements
- R1: A stop write (`wr_en` and `wr_stop` both high for one cycle) is accepted only while `master_mode` is 1. In any other mode the write leaves `stop_req_o` at 0.
- R2: A write that has `wr_start` and `wr_stop` both set never sets the stop request.
- R3: With `tx_dir` = 1 (transmit), a write is accepted only while `in_wait9` is 1. In receive it is also accepted in `in_wait8`, provided `wait8_mode` is 1. An accepted write shows `stop_req_o` = 1 from the next cycle on.
- R4: Each of the following drops `stop_req_o` and both line enables to 0 by the next cycle, and no write is accepted in the same cycle: `arb_lost`, `comm_exit`, or `periph_en` = 0. A reset drops them as well.
- R5: A stop write made while a request is pending raises `stop_err` for exactly one cycle, one cycle later. It does not restart or lengthen the sequence.
- R6: A request accepted in the ninth-clock wait first pulls SDA low. It holds SCL low for `HOLD_CYC` cycles together with SDA, then releases SCL.
- R7: SDA stays pulled low for exactly `SETUP_CYC` cycles in which SCL is seen high. Any cycle with SCL low restarts this count. Only then is SDA released. With no clock stretching, the request is pending for `HOLD_CYC + SETUP_CYC + 1` cycles.
- R8: `stop_done` pulses for one cycle when SDA is seen rising while SCL is high, both in the current and the previous cycle. That pulse clears the request, so `stop_req_o` reads 0 from the next cycle on.
- R9: A request accepted in the eighth-clock wait keeps SDA low and never pulls SCL. Once the eighth-clock wait has ended, the block counts SCL-high cycles, and after `SETUP_CYC` of them it releases SDA. The stop therefore falls in the high phase of the ninth clock.
- R10: After reset, `stop_req_o`, `stop_err`, `stop_done`, `scl_low_en` and `sda_low_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 cancels and blocks requests |
| master_mode | input | 1 | 1 while the master owns the bus |
| tx_dir | input | 1 | 1 = transmit direction, 0 = receive |
| wait8_mode | input | 1 | 1 = wait is inserted after the eighth clock |
| in_wait8 | input | 1 | Bus is in the wait after the eighth clock |
| in_wait9 | input | 1 | Bus is in the wait after the ninth clock |
| arb_lost | input | 1 | Arbitration lost (clear cause) |
| comm_exit | input | 1 | Communication-exit command (clear cause) |
| wr_en | input | 1 | Control-register write strobe |
| wr_stop | input | 1 | Stop-request bit of the write |
| wr_start | input | 1 | Start-request bit of the same write |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| stop_req_o | output | 1 | Stop-request bit as read back |
| stop_err | output | 1 | One-cycle pulse on an illegal rewrite |
| stop_done | output | 1 | One-cycle stop-detected pulse |
| scl_low_en | output | 1 | Pull SCL low |
| sda_low_en | output | 1 | Pull SDA low |

## Verification
The bench sweeps every combination of mode, start bit, direction and wait flags. A legality rule that is checked wrongly shows up there as a request taken during the acknowledge phase or in slave mode. It also catches a combined start-and-stop write that slips through. Full sequences are timed with and without SCL stretching. A design that counts setup from the SCL release rather than from the observed SCL level would let SDA rise too early once the clock is stretched. A rewrite in the middle of a sequence must flag an error without restarting the sequence, which would stretch the pending time. The eighth-clock path must never pull SCL, and it must wait for the ninth high phase.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SDA_LOW,
    ST_SCL_REL,
    ST_SDA_REL
  } stop_state_e;
endpackage

// File: rtl/stop_accept.sv
module stop_accept (
  input  logic wr_en,
  input  logic wr_stop,
  input  logic wr_start,
  input  logic master_mode,
  input  logic periph_en,
  input  logic tx_dir,
  input  logic wait8_mode,
  input  logic in_wait8,
  input  logic in_wait9,
  input  logic pending,
  input  logic cancel,
  output logic go_now,
  output logic go_defer,
  output logic rewrite
);
  logic stop_wr;
  logic legal;

  assign stop_wr = wr_en & wr_stop;
  // Master mode only, never together with a start, never over a pending request.
  assign legal    = stop_wr & ~wr_start & master_mode & periph_en & ~pending & ~cancel;
  assign go_now   = legal & in_wait9;
  // The eighth-clock wait is legal only in receive with wait-on-eighth selected.
  assign go_defer = legal & ~in_wait9 & in_wait8 & wait8_mode & ~tx_dir;
  assign rewrite  = stop_wr & pending;
endmodule

// File: rtl/stop_detect.sv
module stop_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic stop_done
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign stop_done = sda_in & ~sda_q & scl_in & scl_q;

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_done);
endmodule

// File: rtl/stop_seq.sv
module stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int HOLD_CYC  = 4,
  parameter int SETUP_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_now,
  input  logic go_defer,
  input  logic cancel,
  input  logic in_wait8,
  input  logic scl_in,
  input  logic stop_done,
  output logic pending,
  output logic scl_low_en,
  output logic sda_low_en
);
  localparam int MAXC = (HOLD_CYC > SETUP_CYC) ? HOLD_CYC : SETUP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);

  stop_state_e   state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (cancel) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (go_now)        state <= ST_SDA_LOW;
          else if (go_defer) state <= ST_ARM;
        end
        ST_ARM: begin
          if (!in_wait8 && scl_in) begin
            if (SETUP_CYC <= 1) state <= ST_SDA_REL;
            else begin
              state <= ST_SCL_REL;
              cnt   <= CW'(1);
            end
          end
        end
        ST_SDA_LOW: begin
          if (cnt == HOLD_LAST) begin
            state <= ST_SCL_REL;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_SCL_REL: begin
          if (!scl_in)                cnt   <= '0;
          else if (cnt == SETUP_LAST) state <= ST_SDA_REL;
          else                        cnt   <= cnt + 1'b1;
        end
        ST_SDA_REL: begin
          if (stop_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pending    = (state != ST_IDLE);
  assign scl_low_en = (state == ST_SDA_LOW);
  assign sda_low_en = (state == ST_ARM) || (state == ST_SDA_LOW) || (state == ST_SCL_REL);

  assert_release_scl_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_low_en) && !$past(cancel)) |-> $past(scl_in));
endmodule

// File: rtl/i2c_stop_ctrl.sv
module i2c_stop_ctrl #(
  parameter int HOLD_CYC  = 4,
  parameter int SETUP_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic periph_en,
  input  logic master_mode,
  input  logic tx_dir,
  input  logic wait8_mode,
  input  logic in_wait8,
  input  logic in_wait9,
  input  logic arb_lost,
  input  logic comm_exit,
  input  logic wr_en,
  input  logic wr_stop,
  input  logic wr_start,
  input  logic scl_in,
  input  logic sda_in,
  output logic stop_req_o,
  output logic stop_err,
  output logic stop_done,
  output logic scl_low_en,
  output logic sda_low_en
);
  logic cancel;
  logic go_now;
  logic go_defer;
  logic rewrite;
  logic pending;

  assign cancel = arb_lost | comm_exit | ~periph_en;

  stop_accept u_accept (
    .wr_en(wr_en), .wr_stop(wr_stop), .wr_start(wr_start),
    .master_mode(master_mode), .periph_en(periph_en), .tx_dir(tx_dir),
    .wait8_mode(wait8_mode), .in_wait8(in_wait8), .in_wait9(in_wait9),
    .pending(pending), .cancel(cancel),
    .go_now(go_now), .go_defer(go_defer), .rewrite(rewrite)
  );

  stop_seq #(.HOLD_CYC(HOLD_CYC), .SETUP_CYC(SETUP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_now(go_now), .go_defer(go_defer),
    .cancel(cancel), .in_wait8(in_wait8), .scl_in(scl_in),
    .stop_done(stop_done), .pending(pending),
    .scl_low_en(scl_low_en), .sda_low_en(sda_low_en)
  );

  stop_detect u_detect (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .stop_done(stop_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_err <= 1'b0;
    else        stop_err <= rewrite;
  end

  assign stop_req_o = pending;

  assert_master_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stop && !master_mode && !stop_req_o) |=> !stop_req_o);
  assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stop && wr_start && !stop_req_o) |=> !stop_req_o);
  assert_tx_wait9_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stop && tx_dir && !in_wait9 && !stop_req_o) |=> !stop_req_o);
  assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost || comm_exit || !periph_en) |=> (!stop_req_o && !sda_low_en && !scl_low_en));
  assert_err_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_err |-> $past(stop_req_o));
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !stop_req_o);
endmodule

// File: tb/test_i2c_stop_ctrl.sv
`timescale 1ns/1ps
module test_i2c_stop_ctrl;
  localparam int HOLD  = 2;
  localparam int SETUP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en = 1'b1, master_mode = 1'b1, tx_dir = 1'b1, wait8_mode = 1'b0;
  logic in_wait8 = 1'b0, in_wait9 = 1'b0, arb_lost = 1'b0, comm_exit = 1'b0;
  logic wr_en = 1'b0, wr_stop = 1'b0, wr_start = 1'b0;
  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  logic scl_in, sda_in;
  logic stop_req_o, stop_err, stop_done, scl_low_en, sda_low_en;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign scl_in = !(scl_low_en || tb_scl_low);
  assign sda_in = !(sda_low_en || tb_sda_low);

  i2c_stop_ctrl #(.HOLD_CYC(HOLD), .SETUP_CYC(SETUP)) i_i2c_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .master_mode(master_mode),
    .tx_dir(tx_dir), .wait8_mode(wait8_mode), .in_wait8(in_wait8), .in_wait9(in_wait9),
    .arb_lost(arb_lost), .comm_exit(comm_exit), .wr_en(wr_en), .wr_stop(wr_stop),
    .wr_start(wr_start), .scl_in(scl_in), .sda_in(sda_in), .stop_req_o(stop_req_o),
    .stop_err(stop_err), .stop_done(stop_done), .scl_low_en(scl_low_en),
    .sda_low_en(sda_low_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Accept in ninth-clock wait, time the whole sequence.
  task automatic run_stop(input int stretch, input int rew_at);
    int pend = 0, hold = 0, setup = 0, dones = 0, left = 0, i = 0;
    logic prev_scl = 1'b0;
    @(negedge clk); in_wait9 = 1'b1; wr_en = 1'b1; wr_stop = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_stop = 1'b0; in_wait9 = 1'b0; #1;
    chk(sda_low_en && scl_low_en, "R6 both lines pulled first", {scl_low_en, sda_low_en}, 3);
    while (stop_req_o && i < 200) begin
      pend++;
      if (scl_low_en) hold++;
      if (scl_in && sda_low_en) setup++;
      if (stop_done) dones++;
      if (rew_at >= 0 && i == rew_at + 2) chk(stop_err == 1'b1, "R5 error pulse", stop_err, 1);
      if (rew_at >= 0 && i == rew_at + 3) chk(stop_err == 1'b0, "R5 error one cycle", stop_err, 0);
      prev_scl = scl_low_en;
      @(negedge clk);
      wr_en = 1'b0; wr_stop = 1'b0;
      if (i == rew_at) begin wr_en = 1'b1; wr_stop = 1'b1; end
      if (left > 0) begin
        left--;
        if (left == 0) tb_scl_low = 1'b0;
      end
      if (prev_scl && !scl_low_en && stretch > 0) begin
        tb_scl_low = 1'b1;
        left = stretch;
      end
      #1;
      i++;
    end
    chk(hold == HOLD, "R6 SCL hold cycles", hold, HOLD);
    chk(setup == SETUP, "R7 SDA setup cycles with SCL high", setup, SETUP);
    chk(pend == HOLD + SETUP + 1 + stretch, "R7 pending length", pend, HOLD + SETUP + 1 + stretch);
    chk(dones == 1, "R8 single stop pulse", dones, 1);
    chk(stop_req_o == 1'b0, "R8 reads 0 after stop", stop_req_o, 0);
    chk(!sda_low_en && !scl_low_en, "R8 lines released", {scl_low_en, sda_low_en}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk({stop_req_o, stop_err, stop_done, scl_low_en, sda_low_en} == 5'b0, "R10 reset outputs",
        {stop_req_o, stop_err, stop_done, scl_low_en, sda_low_en}, 0);

    // Legality sweep: R1, R2, R3 and R4 cancel.
    for (int v = 0; v < 64; v++) begin
      bit mm, st, tx, w8, w9, wm, exp;
      string tag;
      mm = v[0]; st = v[1]; tx = v[2]; w8 = v[3]; w9 = v[4]; wm = v[5];
      exp = mm && !st && (w9 || (w8 && wm && !tx));
      tag = !mm ? "R1 mode" : (st ? "R2 start+stop" : "R3 wait window");
      @(negedge clk);
      master_mode = mm; wr_start = st; tx_dir = tx; in_wait8 = w8; in_wait9 = w9;
      wait8_mode = wm; wr_en = 1'b1; wr_stop = 1'b1;
      @(negedge clk); wr_en = 1'b0; wr_stop = 1'b0; wr_start = 1'b0; #1;
      chk(stop_req_o == exp, tag, stop_req_o, exp);
      @(negedge clk); comm_exit = 1'b1;
      @(negedge clk); comm_exit = 1'b0; in_wait8 = 1'b0; in_wait9 = 1'b0; #1;
      chk(!stop_req_o && !sda_low_en && !scl_low_en, "R4 comm exit clears",
          {stop_req_o, sda_low_en, scl_low_en}, 0);
    end
    master_mode = 1'b1; tx_dir = 1'b1; wait8_mode = 1'b0;

    // Full sequences: R6, R7, R8, with and without SCL stretching.
    run_stop(0, -1);
    run_stop(4, -1);
    run_stop(1, -1);
    // R5 rewrite during sequence: error pulse, no restart.
    run_stop(0, 0);

    // R4 arbitration loss mid-sequence.
    @(negedge clk); in_wait9 = 1'b1; wr_en = 1'b1; wr_stop = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_stop = 1'b0; in_wait9 = 1'b0;
    arb_lost = 1'b1;
    @(negedge clk); arb_lost = 1'b0; #1;
    chk(!stop_req_o && !sda_low_en && !scl_low_en, "R4 arbitration loss clears",
        {stop_req_o, sda_low_en, scl_low_en}, 0);
    // R4 peripheral disable blocks a write.
    @(negedge clk); periph_en = 1'b0; in_wait9 = 1'b1; wr_en = 1'b1; wr_stop = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_stop = 1'b0; in_wait9 = 1'b0; #1;
    chk(stop_req_o == 1'b0, "R4 disabled ignores write", stop_req_o, 0);
    // R4 disable cancels a pending request.
    @(negedge clk); periph_en = 1'b1; in_wait9 = 1'b1; wr_en = 1'b1; wr_stop = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_stop = 1'b0; in_wait9 = 1'b0; #1;
    chk(stop_req_o == 1'b1, "R3 accepted in ninth wait", stop_req_o, 1);
    @(negedge clk); periph_en = 1'b0;
    @(negedge clk); periph_en = 1'b1; #1;
    chk(stop_req_o == 1'b0, "R4 disable clears", stop_req_o, 0);

    // R9 deferred path in receive with wait-on-eighth.
    begin
      int setup = 0, hold = 0, dones = 0, guard = 0;
      @(negedge clk); tx_dir = 1'b0; wait8_mode = 1'b1; in_wait8 = 1'b1; tb_scl_low = 1'b1;
      wr_en = 1'b1; wr_stop = 1'b1;
      @(negedge clk); wr_en = 1'b0; wr_stop = 1'b0; #1;
      chk(stop_req_o && sda_low_en && !scl_low_en, "R9 armed holds SDA only",
          {stop_req_o, sda_low_en, scl_low_en}, 6);
      repeat (3) step();
      chk(stop_req_o && sda_low_en && !scl_low_en, "R9 still armed in wait",
          {stop_req_o, sda_low_en, scl_low_en}, 6);
      @(negedge clk); in_wait8 = 1'b0;
      repeat (2) step();
      chk(sda_low_en == 1'b1, "R9 waits for ninth high phase", sda_low_en, 1);
      @(negedge clk); tb_scl_low = 1'b0; #1;
      while (stop_req_o && guard < 100) begin
        if (scl_low_en) hold++;
        if (scl_in && sda_low_en) setup++;
        if (stop_done) dones++;
        step();
        guard++;
      end
      chk(hold == 0, "R9 never pulls SCL", hold, 0);
      chk(setup == SETUP, "R9 setup in ninth high phase", setup, SETUP);
      chk(dones == 1, "R9 stop detected", dones, 1);
      chk(stop_req_o == 1'b0, "R8 cleared after deferred stop", stop_req_o, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule